// File: doc/BRIEF.md
# Streaming 16-Point Delay-Feedback FFT

This block computes a 16-point radix-2 decimation-in-frequency FFT on a stream of complex fixed-point samples. The samples arrive one per accepted clock edge. There is no framing signal: the block counts accepted samples itself. The first sample after reset is index 0 of a frame, and every frame is 16 consecutive accepted samples. Four butterfly stages form a chain. Each stage holds the first half of its sub-block in a feedback delay line (8, 4, 2 and 1 words), then butterflies that half against the second half as it arrives. Across the chain this is 15 words of delay storage.

Twiddle rotations sit between the stages. The first two use a small constant cosine/sine table and a complex multiplier. The last one only ever rotates by -j, so it is a swap and a negation. Every butterfly halves its results, so the transform is scaled by 1/16.

The results leave one per clock in bit-reversed bin order, and each result carries its bin number. The second half of a frame's results are differences still held in the delay lines. They leave only while the samples of the following frame are being accepted, so a stream is flushed by feeding one more frame.

Top module: `sdf_fft`

## Requirements
- R1: A sample is accepted only on a clock edge where `in_valid` is high. Idle cycles between samples do not change any result and produce no output.
- R2: For sample components in [-16384, 16383], each output component equals the 16-point DFT of its frame, X[k] = sum over n of x[n]·e^(-j2πkn/16), divided by 16, to within ±4 LSB.
- R3: Output position p of a frame (p = 0..15, counted over valid outputs) carries bin k equal to p with its 4 bits reversed. `out_bin` shows k on every valid output.
- R4: Result number j after reset is triggered by accepted sample j+15. It is presented on the outputs after the 6th rising edge following the edge that accepted that sample, whatever idle cycles lie in between.
- R5: After the first 15 accepted samples, every accepted sample produces exactly one valid output. A run of S accepted samples therefore yields S-15 outputs.
- R6: While reset is asserted, and until 16 samples have been accepted after reset, `out_valid` stays low.
- R7: Reset returns the frame position to 0 and discards partially processed frames, so the first frame after a reset transforms correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a sample on `in_re`/`in_im` |
| in_re | input | DW (16) | Real part of the sample, two's complement |
| in_im | input | DW (16) | Imaginary part of the sample, two's complement |
| out_valid | output | 1 | Marks a result on `out_re`/`out_im` |
| out_re | output | DW (16) | Real part of the result, scaled by 1/16 |
| out_im | output | DW (16) | Imaginary part of the result, scaled by 1/16 |
| out_bin | output | 4 | Bin index of the current result |

## Verification
The chain has seven registers from input to output: one per butterfly stage and one per rotation. A result is therefore due at the 6th edge after the edge that accepted its triggering sample, and that sample is the one 15 places later in the accepted stream.

The bench logs the cycle of every accepted sample and every valid output. It then compares each output's cycle with the logged cycle of sample j+15 plus that fixed offset. It runs this comparison both with unbroken input and with random idle gaps, so timing is checked per result and not only at the start. The values and bin numbers are judged by position in the output stream, against a DFT that the bench computes in floating point.

// File: rtl/sdf_fft_pkg.sv
package sdf_fft_pkg;

  localparam int FFT_N   = 16;
  localparam int LOG2N   = $clog2(FFT_N);
  localparam int KW      = LOG2N - 1;     // twiddle exponent width (0..N/2-1)
  localparam int TW_W    = 16;            // twiddle word width
  localparam int TW_FRAC = 14;            // 1.0 == 2**TW_FRAC

  // cos(2*pi*k/N) in Q1.14
  function automatic logic signed [TW_W-1:0] tw_cos(input logic [KW-1:0] k);
    case (k)
      3'd0:    tw_cos = 16'sd16384;
      3'd1:    tw_cos = 16'sd15137;
      3'd2:    tw_cos = 16'sd11585;
      3'd3:    tw_cos = 16'sd6270;
      3'd4:    tw_cos = 16'sd0;
      3'd5:    tw_cos = -16'sd6270;
      3'd6:    tw_cos = -16'sd11585;
      default: tw_cos = -16'sd15137;
    endcase
  endfunction

  // sin(2*pi*k/N) in Q1.14
  function automatic logic signed [TW_W-1:0] tw_sin(input logic [KW-1:0] k);
    case (k)
      3'd0:    tw_sin = 16'sd0;
      3'd1:    tw_sin = 16'sd6270;
      3'd2:    tw_sin = 16'sd11585;
      3'd3:    tw_sin = 16'sd15137;
      3'd4:    tw_sin = 16'sd16384;
      3'd5:    tw_sin = 16'sd15137;
      3'd6:    tw_sin = 16'sd11585;
      default: tw_sin = 16'sd6270;
    endcase
  endfunction

  function automatic logic [LOG2N-1:0] bit_rev(input logic [LOG2N-1:0] v);
    for (int i = 0; i < LOG2N; i++) bit_rev[i] = v[LOG2N-1-i];
  endfunction

endpackage

// File: rtl/sdf_fft_stage.sv
module sdf_fft_stage #(
  parameter int DW    = 16,
  parameter int CW    = 4,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [CW-1:0]        in_cnt,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic [CW-1:0]        out_cnt,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);

  localparam int SELB = $clog2(DEPTH);

  // feedback delay line, index DEPTH-1 is the oldest word
  logic signed [DW-1:0] dl_re [DEPTH];
  logic signed [DW-1:0] dl_im [DEPTH];

  logic                 bfly;
  logic                 primed_q, primed_d;
  logic                 valid_d;
  logic [DW:0]          sum_re, sum_im, dif_re, dif_im;
  logic signed [DW-1:0] push_re, push_im, res_re, res_im;

  // next-state logic
  always_comb begin
    bfly   = in_cnt[SELB];
    sum_re = {dl_re[DEPTH-1][DW-1], dl_re[DEPTH-1]} + {in_re[DW-1], in_re};
    sum_im = {dl_im[DEPTH-1][DW-1], dl_im[DEPTH-1]} + {in_im[DW-1], in_im};
    dif_re = {dl_re[DEPTH-1][DW-1], dl_re[DEPTH-1]} - {in_re[DW-1], in_re};
    dif_im = {dl_im[DEPTH-1][DW-1], dl_im[DEPTH-1]} - {in_im[DW-1], in_im};
    if (bfly) begin
      res_re  = sum_re[DW:1];
      res_im  = sum_im[DW:1];
      push_re = dif_re[DW:1];
      push_im = dif_im[DW:1];
    end else begin
      res_re  = dl_re[DEPTH-1];
      res_im  = dl_im[DEPTH-1];
      push_re = in_re;
      push_im = in_im;
    end
    primed_d = primed_q | (in_valid & bfly);
    valid_d  = in_valid & (primed_q | bfly);
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      out_valid <= 1'b0;
      out_cnt   <= '0;
    end else begin
      primed_q  <= primed_d;
      out_valid <= valid_d;
      if (in_valid) out_cnt <= in_cnt - CW'(DEPTH);
    end
  end

  // datapath registers, enabled by accepted samples
  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_re   <= res_re;
      out_im   <= res_im;
      dl_re[0] <= push_re;
      dl_im[0] <= push_im;
      for (int i = 1; i < DEPTH; i++) begin
        dl_re[i] <= dl_re[i-1];
        dl_im[i] <= dl_im[i-1];
      end
    end
  end

  // R5: an output is only ever produced by a sample accepted one edge earlier
  a_r5_out_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R6: a fill-phase sample before the first butterfly yields no output
  a_r6_no_output_while_filling: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !primed_q && !in_cnt[SELB]) |=> !out_valid);

endmodule

// File: rtl/sdf_fft_twiddle.sv
module sdf_fft_twiddle
  import sdf_fft_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SHIFT = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [LOG2N-1:0]       in_cnt,
  input  logic signed [DW-1:0]   in_re,
  input  logic signed [DW-1:0]   in_im,
  output logic                   out_valid,
  output logic [LOG2N-1:0]       out_cnt,
  output logic signed [DW-1:0]   out_re,
  output logic signed [DW-1:0]   out_im
);

  localparam int SELB = LOG2N - 1 - SHIFT;
  localparam logic [LOG2N-1:0] LOW_MASK = LOG2N'((1 << SELB) - 1);
  localparam logic signed [DW-1:0] DMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};

  logic [LOG2N-1:0]     k_wide;
  logic [KW-1:0]        k;
  logic signed [DW-1:0] rot_re, rot_im;

  always_comb begin
    k_wide = (in_cnt & LOW_MASK) << SHIFT;
    k      = in_cnt[SELB] ? k_wide[KW-1:0] : '0;
  end

  generate
    if (SHIFT == LOG2N - 2) begin : g_neg_j
      // only exponent N/4 occurs here: multiply by -j
      always_comb begin
        if (k != '0) begin
          rot_re = in_im;
          rot_im = (in_re == DMIN) ? DMAX : -in_re;
        end else begin
          rot_re = in_re;
          rot_im = in_im;
        end
      end
    end else begin : g_cmul
      localparam int PW = DW + TW_W + 2;
      localparam logic signed [PW-1:0] SAT_HI = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
      localparam logic signed [PW-1:0] SAT_LO = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
      localparam logic signed [PW-1:0] RND    = PW'(1) <<< (TW_FRAC - 1);

      logic signed [PW-1:0] a_x, b_x, wr_x, wi_x, acc_re, acc_im;

      function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
        if (v > SAT_HI)      sat = DMAX;
        else if (v < SAT_LO) sat = DMIN;
        else                 sat = v[DW-1:0];
      endfunction

      always_comb begin
        a_x    = PW'(in_re);
        b_x    = PW'(in_im);
        wr_x   = PW'(tw_cos(k));
        wi_x   = -PW'(tw_sin(k));
        acc_re = (a_x * wr_x - b_x * wi_x + RND) >>> TW_FRAC;
        acc_im = (a_x * wi_x + b_x * wr_x + RND) >>> TW_FRAC;
        rot_re = sat(acc_re);
        rot_im = sat(acc_im);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cnt   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_cnt <= in_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_re <= rot_re;
      out_im <= rot_im;
    end
  end

  // R1: an idle cycle leaves the rotator output untouched and unflagged
  a_r1_rotator_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_re) && $stable(out_im)));

endmodule

// File: rtl/sdf_fft.sv
module sdf_fft
  import sdf_fft_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   in_re,
  input  logic signed [DW-1:0]   in_im,
  output logic                   out_valid,
  output logic signed [DW-1:0]   out_re,
  output logic signed [DW-1:0]   out_im,
  output logic [LOG2N-1:0]       out_bin
);

  localparam int SW = LOG2N + 1;

  logic [LOG2N-1:0] cnt_q, cnt_d;

  // stage inputs (s_*) and stage outputs (t_*)
  logic                 s_v  [LOG2N];
  logic [LOG2N-1:0]     s_c  [LOG2N];
  logic signed [DW-1:0] s_re [LOG2N];
  logic signed [DW-1:0] s_im [LOG2N];
  logic                 t_v  [LOG2N];
  logic [LOG2N-1:0]     t_c  [LOG2N];
  logic signed [DW-1:0] t_re [LOG2N];
  logic signed [DW-1:0] t_im [LOG2N];

  always_comb cnt_d = cnt_q + LOG2N'(in_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign s_v[0]  = in_valid;
  assign s_c[0]  = cnt_q;
  assign s_re[0] = in_re;
  assign s_im[0] = in_im;

  generate
    for (genvar gs = 0; gs < LOG2N; gs++) begin : g_stage
      sdf_fft_stage #(
        .DW    (DW),
        .CW    (LOG2N),
        .DEPTH (FFT_N >> (gs + 1))
      ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_v[gs]),
        .in_cnt    (s_c[gs]),
        .in_re     (s_re[gs]),
        .in_im     (s_im[gs]),
        .out_valid (t_v[gs]),
        .out_cnt   (t_c[gs]),
        .out_re    (t_re[gs]),
        .out_im    (t_im[gs])
      );
      if (gs < LOG2N - 1) begin : g_rot
        sdf_fft_twiddle #(
          .DW    (DW),
          .SHIFT (gs)
        ) u_rot (
          .clk       (clk),
          .rst_n     (rst_n),
          .in_valid  (t_v[gs]),
          .in_cnt    (t_c[gs]),
          .in_re     (t_re[gs]),
          .in_im     (t_im[gs]),
          .out_valid (s_v[gs+1]),
          .out_cnt   (s_c[gs+1]),
          .out_re    (s_re[gs+1]),
          .out_im    (s_im[gs+1])
        );
      end
    end
  endgenerate

  assign out_valid = t_v[LOG2N-1];
  assign out_re    = t_re[LOG2N-1];
  assign out_im    = t_im[LOG2N-1];
  assign out_bin   = bit_rev(t_c[LOG2N-1]);

  // R1: the frame position advances only on accepted samples
  a_r1_count_holds_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q));

  // observation state for the checks below
  logic [SW-1:0]    seen_q;
  logic [LOG2N-1:0] last_pos_q;
  logic             have_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= '0;
      last_pos_q  <= '0;
      have_last_q <= 1'b0;
    end else begin
      if (in_valid && seen_q != SW'(FFT_N)) seen_q <= seen_q + 1'b1;
      if (out_valid) begin
        last_pos_q  <= t_c[LOG2N-1];
        have_last_q <= 1'b1;
      end
    end
  end

  // R6: no result before a full frame has been accepted
  a_r6_no_early_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen_q == SW'(FFT_N)));

  // R3: consecutive results walk the frame positions in order
  a_r3_position_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && have_last_q) |-> (t_c[LOG2N-1] == last_pos_q + 1'b1));

endmodule

// File: tb/tb_sdf_fft.sv
module tb_sdf_fft;

  localparam int DW   = 16;
  localparam int N    = 16;
  localparam int MAXS = 16 * 26;
  localparam int LAT  = 7;    // negedge-to-negedge cycles from drive to result
  localparam int TOL  = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_re;
  logic signed [DW-1:0] out_im;
  logic [3:0]           out_bin;

  sdf_fft #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_bin(out_bin)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int errors = 0;
  int checks = 0;

  int xr [MAXS];
  int xi [MAXS];
  int ic [MAXS];
  int o_re [MAXS];
  int o_im [MAXS];
  int o_bin [MAXS];
  int o_cyc [MAXS];
  int no = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && no < MAXS) begin
      o_re[no]  = int'(out_re);
      o_im[no]  = int'(out_im);
      o_bin[no] = int'(out_bin);
      o_cyc[no] = cyc;
      no++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int brev4(input int v);
    return ((v & 1) << 3) | ((v & 2) << 1) | ((v & 4) >> 1) | ((v & 8) >> 3);
  endfunction

  function automatic real ref_re(input int f, input int k);
    real acc = 0.0;
    for (int n = 0; n < N; n++) begin
      real th = -2.0 * 3.14159265358979 * k * n / N;
      acc += xr[f*N+n] * $cos(th) - xi[f*N+n] * $sin(th);
    end
    return acc / N;
  endfunction

  function automatic real ref_im(input int f, input int k);
    real acc = 0.0;
    for (int n = 0; n < N; n++) begin
      real th = -2.0 * 3.14159265358979 * k * n / N;
      acc += xr[f*N+n] * $sin(th) + xi[f*N+n] * $cos(th);
    end
    return acc / N;
  endfunction

  function automatic int rnd_sample();
    return int'($urandom_range(0, 32767)) - 16384;
  endfunction

  // kind 0: random frames; kind 1: directed frames first
  task automatic fill(input int nfr, input int kind);
    for (int i = 0; i < (nfr + 1) * N; i++) begin
      int f = i / N;
      int n = i % N;
      if (f == nfr) begin xr[i] = 0; xi[i] = 0; end
      else if (kind == 1 && f == 0) begin xr[i] = (n == 0) ? 8000 : 0; xi[i] = (n == 0) ? -4000 : 0; end
      else if (kind == 1 && f == 1) begin xr[i] = 4000; xi[i] = 0; end
      else if (kind == 1 && f == 2) begin
        xr[i] = $rtoi(12000.0 * $cos(2.0 * 3.14159265358979 * 3 * n / N));
        xi[i] = $rtoi(12000.0 * $sin(2.0 * 3.14159265358979 * 3 * n / N));
      end
      else if (kind == 1 && f == 3) begin xr[i] = (n % 2 == 0) ? 9000 : -9000; xi[i] = -5000; end
      else if (kind == 1 && f == 4) begin xr[i] = (n < 8) ? 16383 : -16384; xi[i] = xr[i]; end
      else begin xr[i] = rnd_sample(); xi[i] = rnd_sample(); end
    end
  endtask

  task automatic run(input int nfr, input int gap_pct, input int kind, input bit after_reset);
    int total = (nfr + 1) * N;
    fill(nfr, kind);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6", "out_valid during reset", int'(out_valid), 0);
    no = 0;
    rst_n = 1'b1;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      while (int'($urandom_range(0, 99)) < gap_pct) begin
        in_valid = 1'b0;
        in_re = DW'($urandom_range(0, 65535));
        in_im = DW'($urandom_range(0, 65535));
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_re = DW'(xr[i]);
      in_im = DW'(xi[i]);
      ic[i] = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (20) @(negedge clk);

    chk(no == total - 15, "R5", "output count", no, total - 15);
    for (int j = 0; j < no && j + 15 < total; j++) begin
      int f = j / N;
      int k = brev4(j % N);
      real er = ref_re(f, k);
      real ei = ref_im(f, k);
      string vt = (after_reset && j < N) ? "R7" : "R2";
      chk(o_bin[j] == k, "R3", "bin index", o_bin[j], k);
      chk((real'(o_re[j]) - er) <= TOL && (er - real'(o_re[j])) <= TOL, vt, "real part", o_re[j], $rtoi(er));
      chk((real'(o_im[j]) - ei) <= TOL && (ei - real'(o_im[j])) <= TOL, vt, "imag part", o_im[j], $rtoi(ei));
      chk(o_cyc[j] == ic[j+15] + LAT, (gap_pct > 0) ? "R1" : "R4", "output cycle",
          o_cyc[j], ic[j+15] + LAT);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    // R2 R3 R4 R5 R6: directed frames then random ones, unbroken stream
    run(8, 0, 1, 1'b0);
    // R1 R7: reset left partial frames in flight; random gaps
    run(10, 30, 0, 1'b1);
    // R4 R7: unbroken random stream after another reset
    run(12, 0, 0, 1'b1);
    // R1: heavy gaps
    run(6, 60, 0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule